// File: doc/BRIEF.md
# DMA Channel Transfer Counter

This block holds the control word and the transfer count of one DMA channel. A 16-bit control port selects the address mode (dual or single) and the single-address transfer direction. It also loads and reads back the upper byte of the count. A second 16-bit port loads and reads the low count bits. Each transfer-done strobe from the channel sequencer lowers the count by one.

The counter is 16 bits wide in block-transfer mode and 24 bits wide in single/successive mode. The `blk_mode` input selects the width and decides where the upper byte lands. When a decrement reaches zero, the block latches an interrupt cause. In single-address mode it also pulses an end-of-transfer output. A strobe at a count of zero is still accepted, and the count wraps to all ones. The direction bit is routed to `dir_out` for the single-address data path.

Count loads are honoured only while the channel is disabled. The mode bits can be written at any time.

Top module: `dma_tc_channel`

## Requirements
- R1: After a synchronous active-low reset the following are all 0: `ctl_rdata`, `lo_rdata`, `irq_flag`, `eot` and `dir_out`. The channel is then in single-address, memory-read mode with a count of 0.
- R2: A control write stores bit 15 as the address mode (1 = dual, 0 = single) and bit 14 as the direction (1 = I/O to memory, 0 = memory to I/O). Both bits read back in the same positions. Bits 13:8 always read as 0.
- R3: `dir_out` equals the stored bit 14 while single-address mode is selected. It is 0 while dual-address mode is selected, whatever bit 14 holds.
- R4: With `blk_mode`=1 the counter is 16 bits wide and counter bits 23:16 are held at zero. Control bits 7:0 map to counter bits 15:8. `lo_wdata[7:0]` maps to counter bits 7:0, `lo_rdata[7:0]` returns them and `lo_rdata[15:8]` reads 0.
- R5: With `blk_mode`=0 the counter is 24 bits wide. Control bits 7:0 map to counter bits 23:16, and the low port maps to counter bits 15:0.
- R6: A one-cycle `xfer_done` while `ch_en`=1 lowers the count by exactly one at the next clock edge. While `ch_en`=0 the strobe has no effect on the count.
- R7: A decrement that yields zero sets `irq_flag` at the same edge the count becomes zero. In single-address mode `eot` is high for exactly that one cycle.
- R8: In dual-address mode a decrement to zero sets `irq_flag` but leaves `eot` low. The address mode used is the one held before that edge.
- R9: A strobe at a count of zero is accepted. The count wraps to 0xFFFF in block mode or to 0xFFFFFF in successive mode, and the wrap raises neither `irq_flag` nor `eot`.
- R10: While `ch_en`=1, count writes through either port are ignored. Control writes still update bits 15 and 14.
- R11: `irq_flag` stays set until `irq_clr` is high for a cycle. If a set and a clear happen in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_en | input | 1 | Channel enable; blocks count writes and gates strobes |
| blk_mode | input | 1 | 1 = block-transfer mode (16-bit count), 0 = single/successive (24-bit) |
| xfer_done | input | 1 | One-cycle strobe per completed transfer |
| ctl_we | input | 1 | Control register write enable |
| ctl_wdata | input | 16 | Control write data: mode, direction, upper count byte |
| ctl_rdata | output | 16 | Control read data |
| lo_we | input | 1 | Low count register write enable |
| lo_wdata | input | 16 | Low count write data |
| lo_rdata | output | 16 | Low count read data |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt cause |
| irq_flag | output | 1 | Sticky interrupt cause: count reached zero |
| eot | output | 1 | End-of-transfer pulse, single-address mode only |
| dir_out | output | 1 | Single-address transfer direction, 1 = into memory |

## Verification
A corrupted count shows at both read ports in the cycle right after the faulty edge. If the faulty count is a wrong zero, it also shows as an early `irq_flag` or `eot` at that same edge. A wrong width or byte mapping appears as soon as a load is read back, or when a wrap stops at the wrong value. A mode bit latched wrongly surfaces on `dir_out` at once. At the next zero crossing it also surfaces as a missing or extra `eot`.

// File: rtl/dma_tc_pkg.sv
package dma_tc_pkg;
    localparam int TC_FULL_W = 24;
    localparam int TC_BLK_W  = 16;
    localparam int TC_REG_W  = 16;
    localparam int TC_BYTE_W = 8;

    typedef struct packed {
        logic dual;
        logic dir;
    } tc_mode_t;

    typedef struct packed {
        logic irq;
        logic eot;
    } tc_evt_t;
endpackage

// File: rtl/dma_tc_mode.sv
module dma_tc_mode
    import dma_tc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  logic     dual_in,
    input  logic     dir_in,
    output tc_mode_t mode_q,
    output logic     dir_out
);
    tc_mode_t mode_d;

    always_comb begin
        mode_d = mode_q;
        if (wr_en) begin
            mode_d.dual = dual_in;
            mode_d.dir  = dir_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_d;
    end

    // direction only matters for the single-address path
    assign dir_out = mode_q.dir & ~mode_q.dual;
endmodule

// File: rtl/dma_tc_count.sv
module dma_tc_count #(
    parameter int FULL_W = dma_tc_pkg::TC_FULL_W,
    parameter int BLK_W  = dma_tc_pkg::TC_BLK_W,
    parameter int BYTE_W = dma_tc_pkg::TC_BYTE_W,
    parameter int LO_W   = dma_tc_pkg::TC_REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              blk,
    input  logic              step,
    input  logic              hi_we,
    input  logic [BYTE_W-1:0] hi_wdata,
    input  logic              lo_we,
    input  logic [LO_W-1:0]   lo_wdata,
    output logic [FULL_W-1:0] cnt_q,
    output logic              hit
);
    localparam int HI_BLK_LSB  = BLK_W - BYTE_W;
    localparam int HI_FULL_LSB = FULL_W - BYTE_W;
    localparam int LO_BLK_W    = BLK_W - BYTE_W;

    logic [FULL_W-1:0] cnt_d;
    logic [FULL_W-1:0] dec;
    logic [FULL_W-1:0] blk_mask;

    // mask that keeps only the block-mode width
    genvar gi;
    generate
        for (gi = 0; gi < FULL_W; gi++) begin : g_mask
            if (gi < BLK_W) begin : g_keep
                assign blk_mask[gi] = 1'b1;
            end else begin : g_drop
                assign blk_mask[gi] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        cnt_d = cnt_q;
        hit   = 1'b0;
        dec   = cnt_q - 1'b1;
        if (blk) dec = dec & blk_mask;
        if (!en) begin
            if (hi_we) begin
                if (blk) cnt_d[HI_BLK_LSB +: BYTE_W]  = hi_wdata;
                else     cnt_d[HI_FULL_LSB +: BYTE_W] = hi_wdata;
            end
            if (lo_we) begin
                if (blk) cnt_d[0 +: LO_BLK_W] = lo_wdata[LO_BLK_W-1:0];
                else     cnt_d[0 +: LO_W]     = lo_wdata;
            end
        end else if (step) begin
            cnt_d = dec;
            hit   = (dec == '0);
        end
        if (blk) cnt_d = cnt_d & blk_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dma_tc_event.sv
module dma_tc_event
    import dma_tc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    hit,
    input  logic    dual,
    input  logic    clr,
    output tc_evt_t evt_q
);
    tc_evt_t evt_d;

    always_comb begin
        evt_d.irq = hit | (evt_q.irq & ~clr);
        evt_d.eot = hit & ~dual;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= evt_d;
    end
endmodule

// File: rtl/dma_tc_channel.sv
module dma_tc_channel
    import dma_tc_pkg::*;
#(
    parameter int FULL_W = TC_FULL_W,
    parameter int BLK_W  = TC_BLK_W,
    parameter int REG_W  = TC_REG_W,
    parameter int BYTE_W = TC_BYTE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ch_en,
    input  logic             blk_mode,
    input  logic             xfer_done,
    input  logic             ctl_we,
    input  logic [REG_W-1:0] ctl_wdata,
    output logic [REG_W-1:0] ctl_rdata,
    input  logic             lo_we,
    input  logic [REG_W-1:0] lo_wdata,
    output logic [REG_W-1:0] lo_rdata,
    input  logic             irq_clr,
    output logic             irq_flag,
    output logic             eot,
    output logic             dir_out
);
    localparam int RSV_W       = REG_W - 2 - BYTE_W;
    localparam int HI_BLK_LSB  = BLK_W - BYTE_W;
    localparam int HI_FULL_LSB = FULL_W - BYTE_W;
    localparam int LO_BLK_W    = BLK_W - BYTE_W;

    tc_mode_t          mode_q;
    tc_evt_t           evt_q;
    logic [FULL_W-1:0] cnt_q;
    logic              hit;
    logic [BYTE_W-1:0] hi_rd;

    dma_tc_mode u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_we),
        .dual_in (ctl_wdata[REG_W-1]),
        .dir_in  (ctl_wdata[REG_W-2]),
        .mode_q  (mode_q),
        .dir_out (dir_out)
    );

    dma_tc_count #(
        .FULL_W (FULL_W),
        .BLK_W  (BLK_W),
        .BYTE_W (BYTE_W),
        .LO_W   (REG_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ch_en),
        .blk      (blk_mode),
        .step     (xfer_done),
        .hi_we    (ctl_we),
        .hi_wdata (ctl_wdata[BYTE_W-1:0]),
        .lo_we    (lo_we),
        .lo_wdata (lo_wdata),
        .cnt_q    (cnt_q),
        .hit      (hit)
    );

    dma_tc_event u_event (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .dual  (mode_q.dual),
        .clr   (irq_clr),
        .evt_q (evt_q)
    );

    always_comb begin
        hi_rd = blk_mode ? cnt_q[HI_BLK_LSB +: BYTE_W] : cnt_q[HI_FULL_LSB +: BYTE_W];
        ctl_rdata = {mode_q.dual, mode_q.dir, {RSV_W{1'b0}}, hi_rd};
        if (blk_mode) lo_rdata = {{(REG_W-LO_BLK_W){1'b0}}, cnt_q[LO_BLK_W-1:0]};
        else          lo_rdata = cnt_q[REG_W-1:0];
    end

    assign irq_flag = evt_q.irq;
    assign eot      = evt_q.eot;
endmodule

// File: rtl/dma_tc_channel_chk.sv
module dma_tc_channel_chk #(
    parameter int REG_W  = dma_tc_pkg::TC_REG_W,
    parameter int BYTE_W = dma_tc_pkg::TC_BYTE_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ch_en,
    input logic             blk_mode,
    input logic             xfer_done,
    input logic             ctl_we,
    input logic             lo_we,
    input logic             irq_clr,
    input logic [REG_W-1:0] ctl_rdata,
    input logic [REG_W-1:0] lo_rdata,
    input logic             irq_flag,
    input logic             eot,
    input logic             dir_out
);
    // R3
    dual_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[REG_W-1] |-> !dir_out);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ch_en && !ctl_we && !lo_we) |=>
            ($stable(lo_rdata) || blk_mode != $past(blk_mode)));

    // R10
    busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en && !xfer_done && lo_we) |=>
            ($stable(lo_rdata) || blk_mode != $past(blk_mode)));

    // R7
    eot_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eot |=> !eot);

    // R7
    eot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eot |-> (irq_flag && lo_rdata == '0 && ctl_rdata[BYTE_W-1:0] == '0));

    // R8
    eot_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eot) |-> !$past(ctl_rdata[REG_W-1]));

    // R11
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !(ch_en && xfer_done)) |=> !irq_flag);
endmodule

bind dma_tc_channel dma_tc_channel_chk #(.REG_W(REG_W), .BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ch_en     (ch_en),
    .blk_mode  (blk_mode),
    .xfer_done (xfer_done),
    .ctl_we    (ctl_we),
    .lo_we     (lo_we),
    .irq_clr   (irq_clr),
    .ctl_rdata (ctl_rdata),
    .lo_rdata  (lo_rdata),
    .irq_flag  (irq_flag),
    .eot       (eot),
    .dir_out   (dir_out)
);

// File: tb/dma_tc_channel_tb.sv
module dma_tc_channel_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ch_en = 1'b0, blk_mode = 1'b0, xfer_done = 1'b0;
    logic        ctl_we = 1'b0, lo_we = 1'b0, irq_clr = 1'b0;
    logic [15:0] ctl_wdata = '0, lo_wdata = '0;
    logic [15:0] ctl_rdata, lo_rdata;
    logic        irq_flag, eot, dir_out;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    bit [23:0] m_cnt = '0;
    bit        m_dual = 1'b0, m_dir = 1'b0, m_irq = 1'b0, m_eot = 1'b0;

    always #5 clk = ~clk;

    dma_tc_channel dut_i (
        .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .blk_mode(blk_mode),
        .xfer_done(xfer_done), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .lo_we(lo_we), .lo_wdata(lo_wdata),
        .lo_rdata(lo_rdata), .irq_clr(irq_clr), .irq_flag(irq_flag),
        .eot(eot), .dir_out(dir_out)
    );

    function automatic bit [15:0] exp_ctl(bit blk);
        return {m_dual, m_dir, 6'b0, blk ? m_cnt[15:8] : m_cnt[23:16]};
    endfunction

    function automatic bit [15:0] exp_lo(bit blk);
        return blk ? {8'h00, m_cnt[7:0]} : m_cnt[15:0];
    endfunction

    task automatic chk(string tag, string what, logic [23:0] act, logic [23:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        chk(tag, "ctl_rdata", {8'h0, ctl_rdata}, {8'h0, exp_ctl(blk_mode)});
        chk(tag, "lo_rdata",  {8'h0, lo_rdata},  {8'h0, exp_lo(blk_mode)});
        chk(tag, "irq_flag",  {23'h0, irq_flag}, {23'h0, m_irq});
        chk(tag, "eot",       {23'h0, eot},      {23'h0, m_eot});
        chk(tag, "dir_out",   {23'h0, dir_out},  {23'h0, m_dir & ~m_dual});
    endtask

    // one clock: drive at negedge, update model after the edge, compare
    task automatic tick(input bit en, input bit blk, input bit done,
                        input bit cwe, input bit [15:0] cwd,
                        input bit lwe, input bit [15:0] lwd,
                        input bit clr, input string tag);
        bit old_dual;
        bit hit;
        @(negedge clk);
        ch_en = en; blk_mode = blk; xfer_done = done;
        ctl_we = cwe; ctl_wdata = cwd; lo_we = lwe; lo_wdata = lwd; irq_clr = clr;
        @(posedge clk);
        #1;
        old_dual = m_dual;
        hit = 1'b0;
        if (cwe) begin
            m_dual = cwd[15];
            m_dir  = cwd[14];
            if (!en) begin
                if (blk) m_cnt[15:8]  = cwd[7:0];
                else     m_cnt[23:16] = cwd[7:0];
            end
        end
        if (lwe && !en) begin
            if (blk) m_cnt[7:0]  = lwd[7:0];
            else     m_cnt[15:0] = lwd;
        end
        if (en && done) begin
            m_cnt = m_cnt - 24'd1;
            if (blk) m_cnt[23:16] = 8'h00;
            hit = (m_cnt == 24'd0);
        end
        if (blk) m_cnt[23:16] = 8'h00;
        m_irq = hit | (m_irq & ~clr);
        m_eot = hit & ~old_dual;
        compare_all(tag);
    endtask

    task automatic idle(input bit en, input bit blk, input string tag);
        tick(en, blk, 1'b0, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, tag);
    endtask

    initial begin
        #1_500_000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        #1;
        compare_all("R1");

        // R2 mode bits and reserved field
        tick(0, 0, 0, 1, 16'hFFFF, 0, 16'h0, 0, "R2");
        chk("R2", "ctl readback", {8'h0, ctl_rdata}, 24'h00C0FF);
        // R3 direction in single mode, ignored in dual mode
        chk("R3", "dir in dual", {23'h0, dir_out}, 24'h0);
        tick(0, 0, 0, 1, 16'h4000, 0, 16'h0, 0, "R3");
        chk("R3", "dir in single", {23'h0, dir_out}, 24'h1);
        tick(0, 0, 0, 1, 16'h0000, 0, 16'h0, 0, "R3");

        // R4 block-mode mapping and decrement
        tick(0, 1, 0, 1, 16'h0012, 0, 16'h0, 0, "R4");
        tick(0, 1, 0, 0, 16'h0, 1, 16'hAB34, 0, "R4");
        chk("R4", "lo read", {8'h0, lo_rdata}, 24'h000034);
        chk("R4", "hi byte", {16'h0, ctl_rdata[7:0]}, 24'h000012);
        // R6 done ignored while disabled
        tick(0, 1, 1, 0, 16'h0, 0, 16'h0, 0, "R6");
        chk("R6", "disabled done", {8'h0, lo_rdata}, 24'h000034);
        repeat (3) tick(1, 1, 1, 0, 16'h0, 0, 16'h0, 0, "R6");
        chk("R6", "three steps", {8'h0, ctl_rdata[7:0], lo_rdata[7:0]}, 24'h001231);

        // R5 successive mapping
        tick(0, 0, 0, 1, 16'h0056, 0, 16'h0, 0, "R5");
        tick(0, 0, 0, 0, 16'h0, 1, 16'h0002, 0, "R5");
        chk("R5", "24-bit load", {ctl_rdata[7:0], lo_rdata}, 24'h560002);
        tick(0, 0, 0, 1, 16'h0000, 0, 16'h0, 0, "R5");

        // R7 reaching zero in single mode
        tick(1, 0, 1, 0, 16'h0, 0, 16'h0, 0, "R7");
        tick(1, 0, 1, 0, 16'h0, 0, 16'h0, 0, "R7");
        chk("R7", "eot at zero", {23'h0, eot}, 24'h1);
        chk("R7", "irq at zero", {23'h0, irq_flag}, 24'h1);
        idle(1, 0, "R7");
        chk("R7", "eot one cycle", {23'h0, eot}, 24'h0);

        // R9 wrap from zero, successive then block
        tick(1, 0, 1, 0, 16'h0, 0, 16'h0, 0, "R9");
        chk("R9", "wrap 24", {ctl_rdata[7:0], lo_rdata}, 24'hFFFFFF);
        chk("R9", "no eot on wrap", {23'h0, eot}, 24'h0);
        // R11 clear
        tick(1, 0, 0, 0, 16'h0, 0, 16'h0, 1, "R11");
        chk("R11", "cleared", {23'h0, irq_flag}, 24'h0);
        tick(0, 1, 0, 1, 16'h0000, 1, 16'h0000, 0, "R9");
        tick(1, 1, 1, 0, 16'h0, 0, 16'h0, 0, "R9");
        chk("R9", "wrap 16", {8'h0, ctl_rdata[7:0], lo_rdata[7:0]}, 24'h00FFFF);
        chk("R9", "no irq on wrap", {23'h0, irq_flag}, 24'h0);

        // R8 dual mode: irq but no eot
        tick(0, 0, 0, 1, 16'h8000, 1, 16'h0001, 0, "R8");
        tick(1, 0, 1, 0, 16'h0, 0, 16'h0, 0, "R8");
        chk("R8", "no eot dual", {23'h0, eot}, 24'h0);
        chk("R8", "irq dual", {23'h0, irq_flag}, 24'h1);

        // R11 set and clear together: set wins
        tick(0, 0, 0, 1, 16'h0000, 1, 16'h0001, 1, "R11");
        chk("R11", "cleared before", {23'h0, irq_flag}, 24'h0);
        tick(1, 0, 1, 0, 16'h0, 0, 16'h0, 1, "R11");
        chk("R11", "set beats clear", {23'h0, irq_flag}, 24'h1);

        // R10 writes while enabled: count held, mode updated
        tick(0, 0, 0, 0, 16'h0, 1, 16'h0010, 1, "R10");
        tick(1, 0, 0, 1, 16'h8055, 0, 16'h0, 0, "R10");
        tick(1, 0, 0, 0, 16'h0, 1, 16'h7777, 0, "R10");
        chk("R10", "count held", {ctl_rdata[7:0], lo_rdata}, 24'h000010);
        chk("R10", "mode updated", {23'h0, ctl_rdata[15]}, 24'h1);

        // constrained random mix
        for (int i = 0; i < 6000; i++) begin
            bit en, blk, done, cwe, lwe, clr;
            bit [15:0] cwd, lwd;
            en   = ($urandom % 10) < 7;
            blk  = (($urandom % 60) == 0) ? ~blk_mode : blk_mode;
            done = ($urandom % 2) == 1;
            cwe  = ($urandom % 20) == 0;
            lwe  = ($urandom % 12) == 0;
            clr  = ($urandom % 10) == 0;
            cwd  = 16'($urandom);
            if (($urandom % 4) != 0) cwd[7:0] = 8'h00;
            lwd  = (($urandom % 4) != 0) ? 16'($urandom % 8) : 16'($urandom);
            tick(en, blk, done, cwe, cwd, lwe, lwd, clr, "R6");
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule